// File: doc/BRIEF.md
# Dual-Channel Compare Timer

A 16-bit up-counting timer with two compare channels. The counter advances on a prescaled internal clock, or on valid edges of an external event input. Each channel has a compare register, a sticky match flag and a timer output pin. A channel's output can toggle on every match. In PWM mode the two matches instead set and reset a shared output state, and channel 0 also restarts the period.

Software reaches the block through a single-cycle write port with a 3-bit address. Address 0 and address 1 load the compare registers of channel 0 and channel 1. Address 2 is control: bit 0 runs the timer, bit 1 selects the external source, bits 3:2 select the valid edges, bit 4 selects PWM mode and bit 5 enables clear-on-match for channel 0. Address 3 holds the per-pin settings: bit 0 and bit 2 are the output enables of pins 0 and 1, and bit 1 and bit 3 are their active levels. Address 4 is the write-1-to-clear port for the flags: bit 0 clears match flag 0, bit 1 clears match flag 1 and bit 2 clears the edge flag.

A compare match is evaluated only in a cycle where the counter steps. It is ignored for a channel whose compare register is being written in that same cycle.

Top module: `tmr_cmp_unit`

## Requirements
- R1: With run set and the internal source selected, the count rises by one every PSC_DIV clocks. With run clear, the count is held at 0.
- R2: The count wraps from 0xFFFF to 0. When clear-on-match (control bit 5) or PWM mode is on, a step taken while the count equals compare 0 loads 0 instead of incrementing.
- R3: Match flag n is set when a counter step produces a value equal to compare n. Writing a compare value equal to the current count raises no match.
- R4: In a cycle where compare n is written, channel n detects no match, even if the step would have produced a match.
- R5: Writing 1 to a flag bit at address 4 clears that flag. A match or edge in the same cycle wins, and the flag stays set.
- R6: In toggle mode (control bit 4 = 0), a match on channel n inverts that channel's output state.
- R7: In PWM mode, a channel 0 match drives both output states active and restarts the period. A channel 1 match drives both states inactive, and it wins if both match in the same cycle.
- R8: An enabled pin drives its active level while its state is active and the inverse level otherwise. A disabled pin always drives the inverse of its active-level bit.
- R9: The external input passes through two synchronising flip-flops. The edge select works as follows: 00 none, 01 rising, 10 falling, 11 both. A valid edge takes effect at the third clock edge after the input changes.
- R10: In external mode, the first valid edge after run starts the counter without incrementing it. Each later valid edge increments it.
- R11: Every valid edge sets the edge flag, including the first edge, which leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| ext_evt | input | 1 | External event input, asynchronous |
| count | output | 16 | Current counter value |
| irq_match | output | 2 | Sticky match flags, one per channel |
| irq_edge | output | 1 | Sticky valid-edge flag |
| tmr_out | output | 2 | Timer output pins |

## Verification
The count, the match flags and the output pins all update at the clock edge that closes the stepping cycle. A register write counts as occurring at the edge that captures it. An external edge becomes visible three edges after the input changes. The bench drives inputs at the falling edge and samples one time unit after each rising edge. For each sample it computes the expected count as half the number of edges since run was set, with a wrap at 16 bits or at the period where one applies, and derives the expected flags and pins from that count.

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit #(
  parameter int CNT_W   = 16,
  parameter int PSC_DIV = 4,
  parameter int AW      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ext_evt,
  output logic [CNT_W-1:0] count,
  output logic [1:0]       irq_match,
  output logic             irq_edge,
  output logic [1:0]       tmr_out
);

  localparam int PSC_W = (PSC_DIV > 1) ? $clog2(PSC_DIV) : 1;
  localparam logic [PSC_W-1:0] PSC_LAST = PSC_W'(PSC_DIV - 1);
  localparam logic [AW-1:0] A_CMP0 = AW'(0);
  localparam logic [AW-1:0] A_CMP1 = AW'(1);
  localparam logic [AW-1:0] A_CTRL = AW'(2);
  localparam logic [AW-1:0] A_CFG  = AW'(3);
  localparam logic [AW-1:0] A_CLR  = AW'(4);

  logic [CNT_W-1:0] cmp [2];
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic [PSC_W-1:0] psc;
  logic       run, src_ext, pwm, clr0, started;
  logic [1:0] edge_sel, en, alv, ff, flag, match, wr_cmp;
  logic [2:0] sync;
  logic       eflag, rise, fall, edge_ok, psc_tick, inc, clr_en, wr_clr;

  assign wr_cmp[0] = wr_en && wr_addr == A_CMP0;
  assign wr_cmp[1] = wr_en && wr_addr == A_CMP1;
  assign wr_clr    = wr_en && wr_addr == A_CLR;

  assign rise     = sync[1] & ~sync[2];
  assign fall     = ~sync[1] & sync[2];
  assign edge_ok  = (edge_sel[0] & rise) | (edge_sel[1] & fall);
  assign psc_tick = (psc == PSC_LAST);
  assign inc      = run & (src_ext ? (edge_ok & started) : psc_tick);
  assign clr_en   = clr0 | pwm;
  assign cnt_nxt  = (clr_en && cnt == cmp[0]) ? '0 : cnt + CNT_W'(1);

  always_comb begin
    for (int n = 0; n < 2; n++)
      match[n] = inc && (cnt_nxt == cmp[n]) && !wr_cmp[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp[0]   <= '1;
      cmp[1]   <= '1;
      run      <= 1'b0;
      src_ext  <= 1'b0;
      edge_sel <= 2'b00;
      pwm      <= 1'b0;
      clr0     <= 1'b0;
      en       <= 2'b00;
      alv      <= 2'b00;
    end else if (wr_en) begin
      case (wr_addr)
        A_CMP0: cmp[0] <= wr_data;
        A_CMP1: cmp[1] <= wr_data;
        A_CTRL: begin
          run      <= wr_data[0];
          src_ext  <= wr_data[1];
          edge_sel <= wr_data[3:2];
          pwm      <= wr_data[4];
          clr0     <= wr_data[5];
        end
        A_CFG: begin
          en  <= {wr_data[2], wr_data[0]};
          alv <= {wr_data[3], wr_data[1]};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], ext_evt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc     <= '0;
      cnt     <= '0;
      started <= 1'b0;
    end else if (!run) begin
      psc     <= '0;
      cnt     <= '0;
      started <= 1'b0;
    end else begin
      psc     <= (src_ext || psc_tick) ? '0 : psc + PSC_W'(1);
      started <= src_ext & (started | edge_ok);
      if (inc) cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 2'b00;
      eflag <= 1'b0;
      ff    <= 2'b00;
    end else begin
      for (int n = 0; n < 2; n++)
        flag[n] <= match[n] | (flag[n] & ~(wr_clr & wr_data[n]));
      eflag <= edge_ok | (eflag & ~(wr_clr & wr_data[2]));
      if (pwm) begin
        if (match[1])      ff <= 2'b00;
        else if (match[0]) ff <= 2'b11;
      end else begin
        ff <= ff ^ match;
      end
    end
  end

  assign count     = cnt;
  assign irq_match = flag;
  assign irq_edge  = eflag;
  assign tmr_out   = ((en & ff) & alv) | (~(en & ff) & ~alv);

  assert_stop_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count == '0);

  assert_no_match_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmp[0] && !irq_match[0]) |=> !irq_match[0]);

  assert_flag_needs_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !irq_match[1]) |=> !irq_match[1]);

  assert_state_needs_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(ff));

  assert_first_edge_no_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && src_ext && !started && edge_ok) |=> count == '0);

  assert_edge_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ok |=> irq_edge);

endmodule

// File: tb/test_tmr_cmp_unit.sv
module test_tmr_cmp_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        ext_evt = 1'b0;
  logic [15:0] count;
  logic [1:0]  irq_match;
  logic        irq_edge;
  logic [1:0]  tmr_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  tmr_cmp_unit #(.CNT_W(16), .PSC_DIV(DIV), .AW(3)) i_tmr_cmp_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_evt(ext_evt), .count(count), .irq_match(irq_match), .irq_edge(irq_edge),
    .tmr_out(tmr_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; ext_evt = 1'b0;
    step(3);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic pulse();
    @(negedge clk); ext_evt = 1'b1; step(4);
    @(negedge clk); ext_evt = 1'b0; step(4);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(1);
    chk("R1", "reset count", count, 0);
    chk("R5", "reset flags", {irq_edge, irq_match}, 0);
    chk("R8", "reset pins inverse of level 0", tmr_out, 2'b11);

    // R1 R3 R6 R8: internal source, toggle mode
    wr(0, 5); wr(1, 3); wr(3, 16'hF); wr(2, 16'h1);
    for (int k = 1; k <= 14; k++) begin
      step(1);
      chk("R1", "prescaled count", count, k / DIV);
      chk("R3", "match flag 0", irq_match[0], k >= 10);
      chk("R3", "match flag 1", irq_match[1], k >= 6);
      chk("R6", "toggle pin 0", tmr_out[0], k >= 10);
      chk("R6", "toggle pin 1", tmr_out[1], k >= 6);
    end
    wr(3, 16'hE);
    chk("R8", "disabled pin with level 1", tmr_out[0], 1'b0);
    wr(3, 16'hC);
    chk("R8", "disabled pin with level 0", tmr_out[0], 1'b1);
    wr(2, 16'h0); step(1);
    chk("R1", "stopped count", count, 0);

    // R2: wrap at 16 bits
    do_reset();
    wr(0, 16'h0000); wr(1, 16'hFFFF); wr(2, 16'h1);
    step(131069);
    chk("R2", "before wrap", count, 16'hFFFE);
    chk("R3", "no early match 1", irq_match[1], 0);
    step(1);
    chk("R2", "at top", count, 16'hFFFF);
    chk("R3", "match at top", irq_match[1], 1);
    chk("R2", "no match 0 yet", irq_match[0], 0);
    step(2);
    chk("R2", "wrapped", count, 0);
    chk("R2", "match 0 on wrap", irq_match[0], 1);

    // R5 R2: clear priority, clear-on-match with compare 0
    do_reset();
    wr(0, 0); wr(2, 16'h21);
    wr(4, 16'h1);
    chk("R5", "clear in idle cycle", irq_match[0], 0);
    wr(4, 16'h1);
    chk("R5", "match beats clear", irq_match[0], 1);
    chk("R2", "cleared count stays 0", count, 0);
    wr(4, 16'h1);
    chk("R5", "clear takes effect", irq_match[0], 0);
    step(1);
    chk("R5", "next match sets", irq_match[0], 1);
    chk("R2", "count still 0", count, 0);

    // R4 R3: suppression on compare write, equal write no match
    do_reset();
    wr(1, 4); wr(0, 16'h100); wr(2, 16'h1);
    step(7);
    chk("R1", "count before write", count, 3);
    wr(1, 4);
    chk("R4", "count reached compare", count, 4);
    chk("R4", "match suppressed by write", irq_match[1], 0);
    wr(0, 4);
    step(3);
    chk("R3", "count moved on", count, 6);
    chk("R3", "equal write gives no match", irq_match[0], 0);

    // R7 R8: PWM mode
    do_reset();
    wr(0, 5); wr(1, 2); wr(3, 16'h9); wr(2, 16'h11);
    for (int k = 1; k <= 40; k++) begin
      int c;
      bit act;
      step(1);
      c = (k / DIV) % 6;
      act = (k >= 10) && (c == 5 || c <= 1);
      chk("R7", "pwm count", count, c);
      chk("R7", "pwm pin 0 low active", tmr_out[0], !act);
      chk("R8", "disabled pin 1", tmr_out[1], 0);
    end

    // R9 R10 R11: external event source
    do_reset();
    wr(2, 16'h7);
    step(2);
    chk("R10", "no edge count", count, 0);
    chk("R11", "no edge flag", irq_edge, 0);
    @(negedge clk); ext_evt = 1'b1;
    step(2);
    chk("R9", "edge not yet through sync", irq_edge, 0);
    step(1);
    chk("R9", "edge at third clock", irq_edge, 1);
    step(1);
    @(negedge clk); ext_evt = 1'b0; step(4);
    chk("R10", "first edge leaves count 0", count, 0);
    chk("R11", "first edge sets flag", irq_edge, 1);
    wr(4, 16'h4);
    chk("R11", "edge flag cleared", irq_edge, 0);
    pulse();
    chk("R10", "second edge counts", count, 1);
    chk("R11", "flag on second edge", irq_edge, 1);
    pulse();
    chk("R10", "third edge counts", count, 2);
    wr(2, 16'hF);
    pulse();
    chk("R9", "both edges", count, 4);
    wr(2, 16'hB);
    pulse();
    chk("R9", "falling only", count, 5);
    wr(2, 16'h3); wr(4, 16'h4);
    pulse();
    chk("R9", "no edge selected count", count, 5);
    chk("R9", "no edge selected flag", irq_edge, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule